// File: doc/BRIEF.md
# Configurable register field cell

This block holds one field of a control/status register that two sides may update. The software side reaches it through a decoded write strobe, a write data bus with per-byte enables and a read strobe. The hardware side offers a data input with an optional write enable. Parameters choose several behaviours:

- how a software write changes the stored bits;
- whether a read clears or sets the field;
- how the hardware write is qualified;
- whether an extra signal gates software writes;
- which side wins when both act in the same cycle;
- whether the field clears itself one cycle after a write;
- whether reset is asynchronous or synchronous.

The stored value is always driven out. Its AND, OR and XOR reductions can be enabled.

The field sits at bus bit offset `FIELD_LSB`. Field bit k follows bus bit `FIELD_LSB+k` and is qualified by byte enable `(FIELD_LSB+k)/8`. Address decode and read-data muxing live outside the block.

Top module: `regfield_cell`

## Requirements
- R1: With `SW_WR`=PLAIN (1), an effective software write loads field bit k from `sw_wdata_i[FIELD_LSB+k]` only when `sw_be_i[(FIELD_LSB+k)/8]` is 1; all other bits keep their value. With `SW_WR`=NONE (0), software writes never change the field. With no active source and `SINGLE_PULSE`=0, the field holds.
- R2: On enabled lanes, a software write combines the data with the field as follows. OR (2) sets the bits where the data is 1. ANDN (3) clears the bits where the data is 1. XOR (4) flips the bits where the data is 1. Disabled lanes are unchanged.
- R3: On enabled lanes, a software write combines the data with the field as follows. AND (5) clears the bits where the data is 0. XNOR (6) flips the bits where the data is 0. Disabled lanes are unchanged.
- R4: CLR_ALL (7) and SET_ALL (8) drive the whole field to zeros or ones on any effective software write, whatever the data and byte enables.
- R5: For a read, `SW_RD`=CLR (1) or SET (2) forces the field to zeros or ones on the edge where `sw_re_i` is 1, and KEEP (0) leaves it alone. An effective software write in the same cycle overrides the read effect.
- R6: `HW_WR` selects when the field loads `hw_data_i`. NONE (0) never loads it. ALWAYS (1) loads it every cycle. EN_HI (2) loads it when `hw_we_i`=1. EN_LO (3) loads it when `hw_we_i`=0.
- R7: `SW_GATE` NONE (0) leaves software writes ungated. HI (1) lets them take effect only when `sw_gate_i`=1. LO (2) lets them take effect only when `sw_gate_i`=0.
- R8: While `rst_ni` is 0 the field loads `RESET_VAL`. With `RST_ASYNC`=1 this happens at once. With `RST_ASYNC`=0 it happens at the next rising clock edge.
- R9: With `SINGLE_PULSE`=1, the field returns to zero on any edge where neither side acts, so a written value lasts one cycle.
- R10: With `REDUCE_EN`=1, `and_o`, `or_o` and `xor_o` give the AND, OR and XOR reductions of `field_o`. With `REDUCE_EN`=0 they are 0.
- R11: When software (write or read effect) and hardware both act in one cycle, `SW_WINS`=1 keeps only the software result and `SW_WINS`=0 keeps only `hw_data_i`.
- R12: With `HW_WR`=ALWAYS and `SW_WINS`=0, the field equals the previous cycle's `hw_data_i` after every edge, whatever software does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sw_we_i | input | 1 | Decoded software write strobe |
| sw_be_i | input | BUS_W/8 | Software byte enables |
| sw_wdata_i | input | BUS_W | Software write data bus |
| sw_re_i | input | 1 | Decoded software read strobe |
| sw_gate_i | input | 1 | External software write gate |
| hw_we_i | input | 1 | Hardware write enable |
| hw_data_i | input | WIDTH | Hardware write data |
| field_o | output | WIDTH | Stored field value |
| and_o | output | 1 | AND reduction of the field |
| or_o | output | 1 | OR reduction of the field |
| xor_o | output | 1 | XOR reduction of the field |

## Verification
The bench builds eleven copies, all 12 bits wide at bus offset 4, so the field spans two byte lanes.

Nine copies take one software write mode each. They cycle through the three read modes, with an active-high hardware enable, an active-high gate, software precedence and asynchronous reset. This reaches every write operation per lane and every read effect in collision with writes and hardware loads.

A tenth copy loads hardware every cycle with hardware precedence. It shows that software is locked out.

The last copy uses an active-low enable and gate, hardware precedence, synchronous reset, single-pulse clearing and no reductions. It reaches the other polarities and the self-clearing path.

// File: rtl/regfield_pkg.sv
package regfield_pkg;
  typedef enum logic [3:0] {
    SW_WR_NONE    = 4'd0,
    SW_WR_PLAIN   = 4'd1,
    SW_WR_OR      = 4'd2,
    SW_WR_ANDN    = 4'd3,
    SW_WR_XOR     = 4'd4,
    SW_WR_AND     = 4'd5,
    SW_WR_XNOR    = 4'd6,
    SW_WR_CLR_ALL = 4'd7,
    SW_WR_SET_ALL = 4'd8
  } sw_wr_e;

  typedef enum logic [1:0] {
    SW_RD_KEEP = 2'd0,
    SW_RD_CLR  = 2'd1,
    SW_RD_SET  = 2'd2
  } sw_rd_e;

  typedef enum logic [1:0] {
    HW_WR_NONE   = 2'd0,
    HW_WR_ALWAYS = 2'd1,
    HW_WR_EN_HI  = 2'd2,
    HW_WR_EN_LO  = 2'd3
  } hw_wr_e;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_HI   = 2'd1,
    GATE_LO   = 2'd2
  } gate_e;
endpackage

// File: rtl/regfield_sw_path.sv
module regfield_sw_path
  import regfield_pkg::*;
#(
  parameter int     WIDTH     = 12,
  parameter int     BUS_W     = 32,
  parameter int     FIELD_LSB = 4,
  parameter sw_wr_e SW_WR     = SW_WR_PLAIN,
  parameter sw_rd_e SW_RD     = SW_RD_KEEP,
  parameter gate_e  SW_GATE   = GATE_NONE,
  localparam int    NLANE     = BUS_W / 8
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             we_i,
  input  logic [NLANE-1:0] be_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic             gate_i,
  output logic             wr_act_o,
  output logic             act_o,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] lane_m, wd, wr_val, rd_val;
  logic             gate_ok, rd_act;
  logic             unused_bus;

  assign unused_bus = ^{wdata_i, be_i};

  for (genvar k = 0; k < WIDTH; k++) begin : gen_bit
    assign lane_m[k] = be_i[(FIELD_LSB + k) / 8];
    assign wd[k]     = wdata_i[FIELD_LSB + k];
  end

  always_comb begin
    case (SW_GATE)
      GATE_HI: gate_ok = gate_i;
      GATE_LO: gate_ok = ~gate_i;
      default: gate_ok = 1'b1;
    endcase
  end

  always_comb begin
    case (SW_WR)
      SW_WR_PLAIN:   wr_val = (q_i & ~lane_m) | (wd & lane_m);
      SW_WR_OR:      wr_val = q_i | (wd & lane_m);
      SW_WR_ANDN:    wr_val = q_i & ~(wd & lane_m);
      SW_WR_XOR:     wr_val = q_i ^ (wd & lane_m);
      SW_WR_AND:     wr_val = q_i & (wd | ~lane_m);
      SW_WR_XNOR:    wr_val = (q_i & ~lane_m) | ((q_i ~^ wd) & lane_m);
      SW_WR_CLR_ALL: wr_val = '0;
      SW_WR_SET_ALL: wr_val = '1;
      default:       wr_val = q_i;
    endcase
  end

  assign wr_act_o = we_i & gate_ok & (SW_WR != SW_WR_NONE);
  assign rd_act   = re_i & (SW_RD != SW_RD_KEEP);
  assign rd_val   = (SW_RD == SW_RD_SET) ? '1 : '0;
  assign act_o    = wr_act_o | rd_act;
  assign next_o   = wr_act_o ? wr_val : rd_val;
endmodule

// File: rtl/regfield_hw_path.sv
module regfield_hw_path
  import regfield_pkg::*;
#(
  parameter hw_wr_e HW_WR = HW_WR_EN_HI
) (
  input  logic we_i,
  output logic act_o
);
  always_comb begin
    case (HW_WR)
      HW_WR_ALWAYS: act_o = 1'b1;
      HW_WR_EN_HI:  act_o = we_i;
      HW_WR_EN_LO:  act_o = ~we_i;
      default:      act_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/regfield_reduce.sv
module regfield_reduce #(
  parameter int WIDTH     = 12,
  parameter bit REDUCE_EN = 1'b1
) (
  input  logic [WIDTH-1:0] q_i,
  output logic             and_o,
  output logic             or_o,
  output logic             xor_o
);
  if (REDUCE_EN) begin : gen_on
    assign and_o = &q_i;
    assign or_o  = |q_i;
    assign xor_o = ^q_i;
  end else begin : gen_off
    logic unused_q;
    assign unused_q = ^q_i;
    assign and_o = 1'b0;
    assign or_o  = 1'b0;
    assign xor_o = 1'b0;
  end
endmodule

// File: rtl/regfield_cell.sv
module regfield_cell
  import regfield_pkg::*;
#(
  parameter int             WIDTH        = 12,
  parameter int             BUS_W        = 32,
  parameter int             FIELD_LSB    = 4,
  parameter logic [WIDTH-1:0] RESET_VAL  = '0,
  parameter sw_wr_e         SW_WR        = SW_WR_PLAIN,
  parameter sw_rd_e         SW_RD        = SW_RD_KEEP,
  parameter hw_wr_e         HW_WR        = HW_WR_EN_HI,
  parameter gate_e          SW_GATE      = GATE_NONE,
  parameter bit             SW_WINS      = 1'b1,
  parameter bit             SINGLE_PULSE = 1'b0,
  parameter bit             RST_ASYNC    = 1'b1,
  parameter bit             REDUCE_EN    = 1'b1,
  localparam int            NLANE        = BUS_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [NLANE-1:0] sw_be_i,
  input  logic [BUS_W-1:0] sw_wdata_i,
  input  logic             sw_re_i,
  input  logic             sw_gate_i,
  input  logic             hw_we_i,
  input  logic [WIDTH-1:0] hw_data_i,
  output logic [WIDTH-1:0] field_o,
  output logic             and_o,
  output logic             or_o,
  output logic             xor_o
);
  logic [WIDTH-1:0] q, d, sw_next;
  logic             sw_act, sw_wr_act, hw_act;

  regfield_sw_path #(
    .WIDTH(WIDTH), .BUS_W(BUS_W), .FIELD_LSB(FIELD_LSB),
    .SW_WR(SW_WR), .SW_RD(SW_RD), .SW_GATE(SW_GATE)
  ) u_sw (
    .q_i(q), .we_i(sw_we_i), .be_i(sw_be_i), .wdata_i(sw_wdata_i),
    .re_i(sw_re_i), .gate_i(sw_gate_i),
    .wr_act_o(sw_wr_act), .act_o(sw_act), .next_o(sw_next)
  );

  regfield_hw_path #(.HW_WR(HW_WR)) u_hw (.we_i(hw_we_i), .act_o(hw_act));

  regfield_reduce #(.WIDTH(WIDTH), .REDUCE_EN(REDUCE_EN)) u_red (
    .q_i(q), .and_o(and_o), .or_o(or_o), .xor_o(xor_o)
  );

  // losing side of a collision is dropped entirely
  always_comb begin
    if (sw_act && hw_act) d = SW_WINS ? sw_next : hw_data_i;
    else if (sw_act)      d = sw_next;
    else if (hw_act)      d = hw_data_i;
    else if (SINGLE_PULSE) d = '0;
    else                  d = q;
  end

  if (RST_ASYNC) begin : gen_arst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RESET_VAL;
      else         q <= d;
    end
  end else begin : gen_srst
    always_ff @(posedge clk_i) begin
      if (!rst_ni) q <= RESET_VAL;
      else         q <= d;
    end
  end

  assign field_o = q;

  assert_hw_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_act && !(sw_act && SW_WINS)) |=> (field_o == $past(hw_data_i)));

  assert_hw_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_act && hw_act && !SW_WINS) |=> (field_o == $past(hw_data_i)));

  assert_sw_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_act && (SW_WINS || !hw_act)) |=> (field_o == $past(sw_next)));

  if (SINGLE_PULSE) begin : gen_sp_chk
    assert_pulse_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sw_act && !hw_act) |=> (field_o == '0));
  end else begin : gen_hold_chk
    assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sw_act && !hw_act) |=> $stable(field_o));
  end

  if (SW_WR == SW_WR_CLR_ALL) begin : gen_clr_chk
    assert_wr_clr_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_wr_act && (SW_WINS || !hw_act)) |=> (field_o == '0));
  end
endmodule

// File: tb/regfield_cell_tb_top.sv
module regfield_cell_tb_top;
  import regfield_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int NI = 11;
  localparam logic [W-1:0] RV_A = 12'hA5C;
  localparam logic [W-1:0] RV_B = 12'h0F0;
  localparam logic [W-1:0] RV_C = 12'h3C3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_we = 1'b0, sw_re = 1'b0, sw_gate = 1'b0, hw_we = 1'b0;
  logic [3:0]  sw_be = '0;
  logic [31:0] sw_wdata = '0;
  logic [W-1:0] hw_data = '0;

  logic [W-1:0] q_w [NI];
  logic and_w [NI];
  logic or_w [NI];
  logic xor_w [NI];
  logic [W-1:0] exp_q [NI];

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar m = 0; m < 9; m++) begin : gen_a
    regfield_cell #(
      .WIDTH(W), .BUS_W(32), .FIELD_LSB(4), .RESET_VAL(RV_A),
      .SW_WR(sw_wr_e'(m)), .SW_RD(sw_rd_e'(m % 3)), .HW_WR(HW_WR_EN_HI),
      .SW_GATE(GATE_HI), .SW_WINS(1'b1), .SINGLE_PULSE(1'b0),
      .RST_ASYNC(1'b1), .REDUCE_EN(1'b1)
    ) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .sw_we_i(sw_we), .sw_be_i(sw_be),
      .sw_wdata_i(sw_wdata), .sw_re_i(sw_re), .sw_gate_i(sw_gate),
      .hw_we_i(hw_we), .hw_data_i(hw_data), .field_o(q_w[m]),
      .and_o(and_w[m]), .or_o(or_w[m]), .xor_o(xor_w[m])
    );
  end

  if (1) begin : gen_b
    regfield_cell #(
      .WIDTH(W), .BUS_W(32), .FIELD_LSB(4), .RESET_VAL(RV_B),
      .SW_WR(SW_WR_PLAIN), .SW_RD(SW_RD_KEEP), .HW_WR(HW_WR_ALWAYS),
      .SW_GATE(GATE_NONE), .SW_WINS(1'b0), .SINGLE_PULSE(1'b0),
      .RST_ASYNC(1'b1), .REDUCE_EN(1'b1)
    ) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .sw_we_i(sw_we), .sw_be_i(sw_be),
      .sw_wdata_i(sw_wdata), .sw_re_i(sw_re), .sw_gate_i(sw_gate),
      .hw_we_i(hw_we), .hw_data_i(hw_data), .field_o(q_w[9]),
      .and_o(and_w[9]), .or_o(or_w[9]), .xor_o(xor_w[9])
    );
  end

  if (1) begin : gen_c
    regfield_cell #(
      .WIDTH(W), .BUS_W(32), .FIELD_LSB(4), .RESET_VAL(RV_C),
      .SW_WR(SW_WR_PLAIN), .SW_RD(SW_RD_CLR), .HW_WR(HW_WR_EN_LO),
      .SW_GATE(GATE_LO), .SW_WINS(1'b0), .SINGLE_PULSE(1'b1),
      .RST_ASYNC(1'b0), .REDUCE_EN(1'b0)
    ) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .sw_we_i(sw_we), .sw_be_i(sw_be),
      .sw_wdata_i(sw_wdata), .sw_re_i(sw_re), .sw_gate_i(sw_gate),
      .hw_we_i(hw_we), .hw_data_i(hw_data), .field_o(q_w[10]),
      .and_o(and_w[10]), .or_o(or_w[10]), .xor_o(xor_w[10])
    );
  end

  function automatic logic [W-1:0] rst_of(int i);
    return (i < 9) ? RV_A : (i == 9) ? RV_B : RV_C;
  endfunction

  // golden next-state model, per bit, from the requirements
  function automatic logic [W-1:0] model(int i, logic [W-1:0] q);
    int swm, rdm, hwm, gm;
    bit swwins, sp, gate_ok, wr, rd, hwact;
    logic [W-1:0] wv, rv;
    swm = (i < 9) ? i : 1;
    rdm = (i < 9) ? i % 3 : (i == 9) ? 0 : 1;
    hwm = (i < 9) ? 2 : (i == 9) ? 1 : 3;
    gm  = (i < 9) ? 1 : (i == 9) ? 0 : 2;
    swwins = (i < 9);
    sp = (i == 10);
    gate_ok = (gm == 0) ? 1'b1 : (gm == 1) ? sw_gate : !sw_gate;
    wr = sw_we && gate_ok && swm != 0;
    for (int k = 0; k < W; k++) begin
      bit l, dbit, b;
      l = sw_be[(4 + k) / 8];
      dbit = sw_wdata[4 + k];
      b = q[k];
      case (swm)
        1: wv[k] = l ? dbit : b;
        2: wv[k] = b | (l & dbit);
        3: wv[k] = b & ~(l & dbit);
        4: wv[k] = b ^ (l & dbit);
        5: wv[k] = l ? (b & dbit) : b;
        6: wv[k] = l ? ~(b ^ dbit) : b;
        7: wv[k] = 1'b0;
        8: wv[k] = 1'b1;
        default: wv[k] = b;
      endcase
    end
    rd = sw_re && rdm != 0;
    rv = (rdm == 2) ? '1 : '0;
    hwact = (hwm == 1) || (hwm == 2 && hw_we) || (hwm == 3 && !hw_we);
    if ((wr || rd) && hwact) return swwins ? (wr ? wv : rv) : hw_data;
    if (wr || rd) return wr ? wv : rv;
    if (hwact) return hw_data;
    if (sp) return '0;
    return q;
  endfunction

  function automatic string tag_of(int i);
    if (i <= 1) return "R1";
    if (i <= 4) return "R2";
    if (i <= 6) return "R3";
    if (i <= 8) return "R4";
    if (i == 9) return "R12";
    return "R9";
  endfunction

  task automatic check_all(string tag);
    for (int i = 0; i < NI; i++) begin
      logic ea, eo, ex;
      string t;
      t = (tag == "") ? tag_of(i) : tag;
      vectors++;
      if (q_w[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s inst %0d field: got %h expected %h", t, i, q_w[i], exp_q[i]);
      end
      ea = (i == 10) ? 1'b0 : &exp_q[i];
      eo = (i == 10) ? 1'b0 : |exp_q[i];
      ex = (i == 10) ? 1'b0 : ^exp_q[i];
      vectors++;
      if ({and_w[i], or_w[i], xor_w[i]} !== {ea, eo, ex}) begin
        errors++;
        $display("FAIL R10 inst %0d reductions: got %b%b%b expected %b%b%b",
                 i, and_w[i], or_w[i], xor_w[i], ea, eo, ex);
      end
    end
  endtask

  // inputs already driven at a negedge; one clock, check at next negedge
  task automatic step(string tag);
    logic [W-1:0] nx [NI];
    for (int i = 0; i < NI; i++) nx[i] = model(i, exp_q[i]);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) exp_q[i] = nx[i];
    check_all(tag);
  endtask

  task automatic idle();
    sw_we = 0; sw_re = 0; sw_be = '0; sw_wdata = '0; hw_we = 0; sw_gate = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    idle();
    hw_we = 1'b1; // keeps the active-low hw enable of inst 10 idle
    repeat (2) @(negedge clk);
    for (int i = 0; i < NI; i++) exp_q[i] = rst_of(i);
    check_all("R8");
    rst_ni = 1'b1;

    // R7: gate low blocks software writes on active-high gated copies
    idle(); hw_we = 1; sw_gate = 0; sw_we = 1; sw_be = 4'hF; sw_wdata = 32'hFFFF_FFF0;
    step("R7");
    // R6: hardware load only
    idle(); hw_we = 1; hw_data = 12'h6B1;
    step("R6");
    // R4: write-all modes ignore data and byte enables
    idle(); hw_we = 1; sw_gate = 1; sw_we = 1; sw_be = 4'h0; sw_wdata = '0;
    step("R4");
    // R5: read effects only
    idle(); hw_we = 1; sw_gate = 1; sw_re = 1;
    step("R5");
    // R11: collision, both polarities of hardware enable and gate
    idle(); hw_we = 1; hw_data = 12'h2D4; sw_gate = 1; sw_we = 1; sw_be = 4'h3;
    sw_wdata = 32'h0000_9A70;
    step("R11");
    idle(); hw_we = 0; hw_data = 12'h71E; sw_gate = 0; sw_we = 1; sw_be = 4'hF;
    sw_wdata = 32'h0000_5550;
    step("R11");
    // R1: single lane of a two-lane field
    idle(); hw_we = 1; sw_gate = 1; sw_we = 1; sw_be = 4'h2; sw_wdata = 32'h0000_F0F0;
    step("R1");

    // R8: asynchronous reset takes effect between edges
    idle(); hw_we = 1;
    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < 10; i++) exp_q[i] = rst_of(i);
    for (int i = 0; i < 10; i++) begin
      vectors++;
      if (q_w[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL R8 inst %0d async reset: got %h expected %h", i, q_w[i], exp_q[i]);
      end
    end
    @(negedge clk);
    exp_q[10] = RV_C;
    check_all("R8");
    rst_ni = 1'b1;

    for (int n = 0; n < 1500; n++) begin
      sw_we    = ($urandom % 3) == 0;
      sw_re    = ($urandom % 5) == 0;
      sw_be    = 4'($urandom);
      sw_wdata = $urandom;
      sw_gate  = ($urandom % 4) != 0;
      hw_we    = ($urandom % 3) == 0;
      hw_data  = W'($urandom);
      step("");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule